// File: doc/BRIEF.md
# Nibble-Coded Register Access Decoder

This block sits on the device side of a byte-wide host link and turns a stream of command bytes into register traffic. Every byte holds an opcode in bits 7:4 and a 4-bit payload in bits 3:0. Separate opcodes load the two halves of an 8-bit register address and the two halves of an 8-bit write value. The byte carrying the upper data half commits the write. A read opcode returns one byte through a small response FIFO.

A read can optionally step the address forward after it returns its byte, so the host can stream consecutive registers in one burst. This is how the two 24-bit capture positions (trigger point and stop point) are fetched. The write side is a small bank of control registers. The mode register also drives an acquisition run flag and a sample-memory readout flag. When the response FIFO is full, input bytes are held back through a valid/ready handshake.

Top module: `nibreg_decoder`

## Requirements
- R1: Opcode 0 loads the payload into address bits 3:0 and opcode 1 loads it into address bits 7:4; the other address half is kept.
- R2: Opcode 2 stores the payload as the pending low data nibble. Opcode 3 writes {payload, pending low nibble} into the addressed write register. The register output shows the new value from the cycle after the byte is accepted. The write map is: 0 clock select, 1 trigger select A, 2 trigger select B, 3 mode, 4 memory row, 5 post-trigger, 6 trigger option, 7 pin view, 15 test.
- R3: Several data low/high pairs after one address all write the same register. For the 16-bit memory row register (address 4), each write shifts the previous low byte up, giving row = {old[7:0], new}.
- R4: Opcode 4 pushes one byte read from the current address into the response FIFO. The read map is:
  - 0: identifier (default 0xA6)
  - 1, 2, 3: trigger position bytes, least significant first
  - 4, 5, 6: stop position bytes, least significant first
  - 7: mode register
  - 12: pin view register
  - 15: test register
  - every other address reads 0x00.
- R5: A read byte with bit 0 set advances the address by one after the read, wrapping 0xFF to 0x00. With bit 0 clear the address is unchanged.
- R6: Opcodes 5 to 15 are accepted and ignored. They change neither the address nor the pending data nibble, write nothing and return nothing.
- R7: Writing 0x0D to the mode register sets the run flag, writing 0x11 clears it, and any other value leaves it unchanged. The readout flag is high exactly while the mode register holds 0x02.
- R8: Responses leave the FIFO in request order. While rsp_valid is high and rsp_ready is low, rsp_data holds steady.
- R9: in_ready is low exactly while the FIFO (4 entries) is full, and no byte is taken then.
- R10: After reset all write registers are zero, the run flag is low, rsp_valid is low, in_ready is high and the address is 0.
- R11: A write to an address outside the write map changes no register output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Command byte present |
| in_ready | output | 1 | Command byte can be taken |
| in_byte | input | 8 | Command byte: opcode 7:4, payload 3:0 |
| rsp_valid | output | 1 | Read response available |
| rsp_ready | input | 1 | Host takes the response |
| rsp_data | output | 8 | Read response byte |
| trig_pos | input | 24 | Captured trigger position |
| stop_pos | input | 24 | Captured stop position |
| clk_sel | output | 8 | Clock select register |
| trig_sel_a | output | 8 | Trigger select A register |
| trig_sel_b | output | 8 | Trigger select B register |
| mode_reg | output | 8 | Mode register |
| mem_row | output | 16 | Memory row register |
| post_trig | output | 8 | Post-trigger register |
| trig_opt | output | 8 | Trigger option register |
| pin_view | output | 8 | Pin view register |
| test_reg | output | 8 | Test register |
| acq_run | output | 1 | Acquisition run flag |
| mem_readout | output | 1 | Sample memory readout flag |

## Verification
Writes are tried as single pairs and as repeated pairs to one address. The repeated pairs separate overwrite from the shifting memory row. Reads run with and without post-increment, across the full position map and the 0xFF wrap, so a wrong byte order, a missing increment or a missing wrap shows up in the returned sequence. Unknown opcodes are placed between a low and a high data nibble, and the result of that write exposes any disturbed state. A burst against a stalled consumer checks back-pressure, the held output and order after release.

// File: rtl/nibreg_pkg.sv
package nibreg_pkg;
  localparam int BYTE_W = 8;
  localparam int NIB_W  = BYTE_W / 2;
  localparam int POS_W  = 24;
  localparam int ROW_W  = 16;

  localparam logic [NIB_W-1:0] OP_ADDR_LO = 4'd0;
  localparam logic [NIB_W-1:0] OP_ADDR_HI = 4'd1;
  localparam logic [NIB_W-1:0] OP_DATA_LO = 4'd2;
  localparam logic [NIB_W-1:0] OP_DATA_HI = 4'd3;
  localparam logic [NIB_W-1:0] OP_READ    = 4'd4;

  localparam logic [BYTE_W-1:0] WA_CLK   = 8'd0;
  localparam logic [BYTE_W-1:0] WA_TSELA = 8'd1;
  localparam logic [BYTE_W-1:0] WA_TSELB = 8'd2;
  localparam logic [BYTE_W-1:0] WA_MODE  = 8'd3;
  localparam logic [BYTE_W-1:0] WA_ROW   = 8'd4;
  localparam logic [BYTE_W-1:0] WA_POST  = 8'd5;
  localparam logic [BYTE_W-1:0] WA_TOPT  = 8'd6;
  localparam logic [BYTE_W-1:0] WA_PVIEW = 8'd7;
  localparam logic [BYTE_W-1:0] WA_TEST  = 8'd15;

  localparam logic [BYTE_W-1:0] RA_ID    = 8'd0;
  localparam logic [BYTE_W-1:0] RA_TRIG  = 8'd1;
  localparam logic [BYTE_W-1:0] RA_STOP  = 8'd4;
  localparam logic [BYTE_W-1:0] RA_MODE  = 8'd7;
  localparam logic [BYTE_W-1:0] RA_PVIEW = 8'd12;
  localparam logic [BYTE_W-1:0] RA_TEST  = 8'd15;

  localparam logic [BYTE_W-1:0] MODE_START   = 8'h0D;
  localparam logic [BYTE_W-1:0] MODE_STOP    = 8'h11;
  localparam logic [BYTE_W-1:0] MODE_READOUT = 8'h02;

  typedef struct packed {
    logic [BYTE_W-1:0] clk_sel;
    logic [BYTE_W-1:0] tsel_a;
    logic [BYTE_W-1:0] tsel_b;
    logic [BYTE_W-1:0] mode;
    logic [ROW_W-1:0]  row;
    logic [BYTE_W-1:0] post;
    logic [BYTE_W-1:0] topt;
    logic [BYTE_W-1:0] pview;
    logic [BYTE_W-1:0] test;
  } wbank_t;

  function automatic logic [BYTE_W-1:0] step_addr(input logic [BYTE_W-1:0] a,
                                                  input logic incr);
    return incr ? a + 8'd1 : a;
  endfunction

  function automatic logic [BYTE_W-1:0] pos_byte(input logic [POS_W-1:0] pos,
                                                 input logic [1:0] idx);
    return pos[idx*BYTE_W +: BYTE_W];
  endfunction
endpackage

// File: rtl/nibreg_parser.sv
module nibreg_parser
  import nibreg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [BYTE_W-1:0] cmd,
  output logic [BYTE_W-1:0] addr_q,
  output logic [NIB_W-1:0]  dlo_q,
  output logic              wr_fire,
  output logic [BYTE_W-1:0] wr_data,
  output logic              rd_fire
);
  logic [NIB_W-1:0] op;
  logic [NIB_W-1:0] pl;

  always_comb begin
    op      = cmd[BYTE_W-1:NIB_W];
    pl      = cmd[NIB_W-1:0];
    wr_fire = accept && (op == OP_DATA_HI);
    rd_fire = accept && (op == OP_READ);
    wr_data = {pl, dlo_q};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      dlo_q  <= '0;
    end else if (accept) begin
      case (op)
        OP_ADDR_LO: addr_q[NIB_W-1:0]      <= pl;
        OP_ADDR_HI: addr_q[BYTE_W-1:NIB_W] <= pl;
        OP_DATA_LO: dlo_q                  <= pl;
        OP_READ:    addr_q                 <= step_addr(addr_q, pl[0]);
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/nibreg_wbank.sv
module nibreg_wbank
  import nibreg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_fire,
  input  logic [BYTE_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  output wbank_t            regs,
  output logic              acq_run,
  output logic              mem_readout
);
  logic mode_hit;

  assign mode_hit    = wr_fire && (wr_addr == WA_MODE);
  assign mem_readout = (regs.mode == MODE_READOUT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      regs <= '0;
    end else if (wr_fire) begin
      case (wr_addr)
        WA_CLK:   regs.clk_sel <= wr_data;
        WA_TSELA: regs.tsel_a  <= wr_data;
        WA_TSELB: regs.tsel_b  <= wr_data;
        WA_MODE:  regs.mode    <= wr_data;
        WA_ROW:   regs.row     <= {regs.row[ROW_W-BYTE_W-1:0], wr_data};
        WA_POST:  regs.post    <= wr_data;
        WA_TOPT:  regs.topt    <= wr_data;
        WA_PVIEW: regs.pview   <= wr_data;
        WA_TEST:  regs.test    <= wr_data;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      acq_run <= 1'b0;
    else if (mode_hit && wr_data == MODE_START)
      acq_run <= 1'b1;
    else if (mode_hit && wr_data == MODE_STOP)
      acq_run <= 1'b0;
  end
endmodule

// File: rtl/nibreg_rdmux.sv
module nibreg_rdmux
  import nibreg_pkg::*;
#(
  parameter logic [BYTE_W-1:0] ID_VALUE = 8'hA6
) (
  input  logic [BYTE_W-1:0] addr,
  input  logic [POS_W-1:0]  trig_pos,
  input  logic [POS_W-1:0]  stop_pos,
  input  logic [BYTE_W-1:0] mode,
  input  logic [BYTE_W-1:0] pview,
  input  logic [BYTE_W-1:0] test,
  output logic [BYTE_W-1:0] rd_data
);
  localparam int POS_BYTES = POS_W / BYTE_W;

  logic [BYTE_W-1:0] trig_off;
  logic [BYTE_W-1:0] stop_off;

  always_comb begin
    trig_off = addr - RA_TRIG;
    stop_off = addr - RA_STOP;
    rd_data  = '0;
    if (addr == RA_ID)
      rd_data = ID_VALUE;
    else if (trig_off < POS_BYTES)
      rd_data = pos_byte(trig_pos, trig_off[1:0]);
    else if (stop_off < POS_BYTES)
      rd_data = pos_byte(stop_pos, stop_off[1:0]);
    else if (addr == RA_MODE)
      rd_data = mode;
    else if (addr == RA_PVIEW)
      rd_data = pview;
    else if (addr == RA_TEST)
      rd_data = test;
  end
endmodule

// File: rtl/nibreg_rspfifo.sv
module nibreg_rspfifo #(
  parameter int DEPTH = 4,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         not_empty,
  output logic         full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;
  logic             do_push, do_pop;

  assign full      = (count == CNT_W'(DEPTH));
  assign not_empty = (count != '0);
  assign head      = mem[rd_ptr];
  assign do_push   = push && !full;
  assign do_pop    = pop && not_empty;

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/nibreg_decoder.sv
module nibreg_decoder
  import nibreg_pkg::*;
#(
  parameter int                FIFO_DEPTH = 4,
  parameter logic [7:0]        ID_VALUE   = 8'hA6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [7:0]  in_byte,
  output logic        rsp_valid,
  input  logic        rsp_ready,
  output logic [7:0]  rsp_data,
  input  logic [23:0] trig_pos,
  input  logic [23:0] stop_pos,
  output logic [7:0]  clk_sel,
  output logic [7:0]  trig_sel_a,
  output logic [7:0]  trig_sel_b,
  output logic [7:0]  mode_reg,
  output logic [15:0] mem_row,
  output logic [7:0]  post_trig,
  output logic [7:0]  trig_opt,
  output logic [7:0]  pin_view,
  output logic [7:0]  test_reg,
  output logic        acq_run,
  output logic        mem_readout
);
  // named internal events, used by the bound checker
  logic              accept;
  logic              fifo_full;
  logic [BYTE_W-1:0] cur_addr;
  logic [NIB_W-1:0]  data_lo;
  logic              wr_fire;
  logic [BYTE_W-1:0] wr_data;
  logic              rd_fire;
  logic [BYTE_W-1:0] rd_data;
  wbank_t            regs;

  assign in_ready = !fifo_full;
  assign accept   = in_valid && in_ready;

  nibreg_parser u_parser (
    .clk(clk), .rst_n(rst_n), .accept(accept), .cmd(in_byte),
    .addr_q(cur_addr), .dlo_q(data_lo), .wr_fire(wr_fire),
    .wr_data(wr_data), .rd_fire(rd_fire)
  );

  nibreg_wbank u_wbank (
    .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire), .wr_addr(cur_addr),
    .wr_data(wr_data), .regs(regs), .acq_run(acq_run),
    .mem_readout(mem_readout)
  );

  nibreg_rdmux #(.ID_VALUE(ID_VALUE)) u_rdmux (
    .addr(cur_addr), .trig_pos(trig_pos), .stop_pos(stop_pos),
    .mode(regs.mode), .pview(regs.pview), .test(regs.test),
    .rd_data(rd_data)
  );

  nibreg_rspfifo #(.DEPTH(FIFO_DEPTH), .W(BYTE_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(rd_fire), .push_data(rd_data),
    .pop(rsp_ready), .head(rsp_data), .not_empty(rsp_valid),
    .full(fifo_full)
  );

  assign clk_sel    = regs.clk_sel;
  assign trig_sel_a = regs.tsel_a;
  assign trig_sel_b = regs.tsel_b;
  assign mode_reg   = regs.mode;
  assign mem_row    = regs.row;
  assign post_trig  = regs.post;
  assign trig_opt   = regs.topt;
  assign pin_view   = regs.pview;
  assign test_reg   = regs.test;
endmodule

// File: rtl/nibreg_chk.sv
module nibreg_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic [7:0] in_byte,
  input logic       rsp_valid,
  input logic       rsp_ready,
  input logic [7:0] rsp_data,
  input logic [7:0] cur_addr,
  input logic [3:0] data_lo,
  input logic       wr_fire,
  input logic [7:0] wr_data,
  input logic [7:0] mode_reg,
  input logic       acq_run,
  input logic [7:0] clk_sel
);
  logic acc;
  assign acc = in_valid && in_ready;

  p_incr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_byte[7:4] == 4'd4 && in_byte[0] |=> cur_addr == $past(cur_addr) + 8'd1);

  p_hold_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_byte[7:4] == 4'd4 && !in_byte[0] |=> $stable(cur_addr));

  p_unknown_op_r6: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_byte[7:4] > 4'd4 |=> $stable(cur_addr) && $stable(data_lo));

  p_rsp_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data));

  p_full_nonempty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> rsp_valid);

  p_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire && cur_addr == 8'd3 && wr_data == 8'h0D |=> acq_run && mode_reg == 8'h0D);

  p_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire && cur_addr == 8'd3 && wr_data == 8'h11 |=> !acq_run);

  p_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire && cur_addr == 8'd0 |=> clk_sel == $past(wr_data));
endmodule

bind nibreg_decoder nibreg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_byte(in_byte), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_data(rsp_data), .cur_addr(cur_addr), .data_lo(data_lo),
  .wr_fire(wr_fire), .wr_data(wr_data), .mode_reg(mode_reg),
  .acq_run(acq_run), .clk_sel(clk_sel)
);

// File: tb/nibreg_decoder_bench.sv
module nibreg_decoder_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_byte = 8'h00;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [7:0]  rsp_data;
  logic [23:0] trig_pos = 24'hC0FFEE;
  logic [23:0] stop_pos = 24'h123456;
  logic [7:0]  clk_sel, trig_sel_a, trig_sel_b, mode_reg, post_trig;
  logic [7:0]  trig_opt, pin_view, test_reg;
  logic [15:0] mem_row;
  logic        acq_run, mem_readout;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  nibreg_decoder u_nibreg_decoder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_byte(in_byte), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data), .trig_pos(trig_pos), .stop_pos(stop_pos),
    .clk_sel(clk_sel), .trig_sel_a(trig_sel_a), .trig_sel_b(trig_sel_b),
    .mode_reg(mode_reg), .mem_row(mem_row), .post_trig(post_trig),
    .trig_opt(trig_opt), .pin_view(pin_view), .test_reg(test_reg),
    .acq_run(acq_run), .mem_readout(mem_readout)
  );

  task automatic chk_eq(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1;
    in_byte  = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic set_addr(input logic [7:0] a);
    send({4'h0, a[3:0]});
    send({4'h1, a[7:4]});
  endtask

  task automatic write_byte(input logic [7:0] d);
    send({4'h2, d[3:0]});
    send({4'h3, d[7:4]});
  endtask

  task automatic pop_exp(input string req, input logic [7:0] exp);
    chk_eq(req, "rsp_valid", int'(rsp_valid), 1);
    chk_eq(req, "rsp_data", int'(rsp_data), int'(exp));
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  task automatic t_reset;
    chk_eq("R10", "in_ready", int'(in_ready), 1);
    chk_eq("R10", "rsp_valid", int'(rsp_valid), 0);
    chk_eq("R10", "acq_run", int'(acq_run), 0);
    chk_eq("R10", "regs ored", int'(clk_sel | trig_sel_a | trig_sel_b | mode_reg |
           post_trig | trig_opt | pin_view | test_reg | mem_row[7:0] | mem_row[15:8]), 0);
    send(8'h40);  // address 0 after reset -> identifier
    pop_exp("R10", 8'hA6);
  endtask

  task automatic t_single_write;
    set_addr(8'h00); write_byte(8'h5A);
    chk_eq("R2", "clk_sel", int'(clk_sel), 8'h5A);
    set_addr(8'h05); write_byte(8'hFF);
    chk_eq("R2", "post_trig", int'(post_trig), 8'hFF);
    chk_eq("R2", "clk_sel kept", int'(clk_sel), 8'h5A);
    send(8'h0C);  // R1: low nibble only, high stays 0 -> address 0x0C
    send(8'h1F);  // R1: high nibble -> address 0xFC
    send(8'h0F);  // address 0xFF
    send(8'h10);  // address 0x0F (test)
    write_byte(8'h3C);
    chk_eq("R1", "test_reg via nibble address", int'(test_reg), 8'h3C);
  endtask

  task automatic t_multi_write;
    set_addr(8'h04); write_byte(8'h12); write_byte(8'h34);
    chk_eq("R3", "mem_row shift", int'(mem_row), 16'h1234);
    set_addr(8'h02); write_byte(8'h20); write_byte(8'h08);
    chk_eq("R3", "trig_sel_b last", int'(trig_sel_b), 8'h08);
  endtask

  task automatic t_burst_read;
    set_addr(8'h01);
    repeat (4) send(8'h41);
    pop_exp("R4", 8'hEE); pop_exp("R4", 8'hFF); pop_exp("R4", 8'hC0); pop_exp("R4", 8'h56);
    repeat (2) send(8'h41);
    pop_exp("R4", 8'h34); pop_exp("R4", 8'h12);
    set_addr(8'h07); write_byte(8'h00);  // pin view 0 unchanged map check
    set_addr(8'h07);
    send(8'h40); send(8'h40);
    pop_exp("R5", 8'h00); pop_exp("R5", 8'h00);
    set_addr(8'h03); write_byte(8'h77);
    set_addr(8'h07); send(8'h40);
    pop_exp("R4", 8'h77);
    set_addr(8'h0C); send(8'h40);
    pop_exp("R4", 8'h00);
  endtask

  task automatic t_wrap;
    set_addr(8'hFF);
    send(8'h41); send(8'h40);
    pop_exp("R5", 8'h00); pop_exp("R5", 8'hA6);
  endtask

  task automatic t_mode;
    set_addr(8'h03); write_byte(8'h0D);
    chk_eq("R7", "acq_run set", int'(acq_run), 1);
    write_byte(8'h02);
    chk_eq("R7", "acq_run kept", int'(acq_run), 1);
    chk_eq("R7", "mem_readout", int'(mem_readout), 1);
    write_byte(8'h11);
    chk_eq("R7", "acq_run clear", int'(acq_run), 0);
    chk_eq("R7", "mem_readout off", int'(mem_readout), 0);
  endtask

  task automatic t_unknown;
    set_addr(8'h0F);
    send(8'h23);
    send(8'h7F); send(8'h5A); send(8'hE1); send(8'h51);
    send(8'h34);
    chk_eq("R6", "test_reg", int'(test_reg), 8'h43);
    send(8'h40);
    pop_exp("R6", 8'h43);
    chk_eq("R6", "no extra response", int'(rsp_valid), 0);
  endtask

  task automatic t_unmapped;
    set_addr(8'h09); write_byte(8'h99);
    chk_eq("R11", "clk_sel", int'(clk_sel), 8'h5A);
    chk_eq("R11", "mode_reg", int'(mode_reg), 8'h11);
    chk_eq("R11", "test_reg", int'(test_reg), 8'h43);
    chk_eq("R11", "mem_row", int'(mem_row), 16'h1234);
    send(8'h40);
    pop_exp("R11", 8'h00);
  endtask

  task automatic t_backpressure;
    set_addr(8'h01);
    repeat (4) send(8'h41);
    chk_eq("R9", "in_ready when full", int'(in_ready), 0);
    in_valid = 1'b1; in_byte = 8'h41;
    repeat (3) @(negedge clk);
    chk_eq("R9", "in_ready still low", int'(in_ready), 0);
    chk_eq("R8", "held data", int'(rsp_data), 8'hEE);
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk_eq("R9", "in_ready after pop", int'(in_ready), 1);
    @(negedge clk);
    in_valid = 1'b0;
    pop_exp("R8", 8'hFF); pop_exp("R8", 8'hC0); pop_exp("R8", 8'h56); pop_exp("R8", 8'h34);
    chk_eq("R8", "drained", int'(rsp_valid), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_single_write;
    t_multi_write;
    t_burst_read;
    t_wrap;
    t_mode;
    t_unknown;
    t_unmapped;
    t_backpressure;
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule